// File: doc/BRIEF.md
# Serial Bank Register Loader

This block sits on a CPU write bus and fills four small bank registers, each five bits wide, one bit per bus write. Every write into the upper half of the address space (address bit 15 set) supplies only data bit 0. The block gathers these bits least significant first. On the fifth bit it stores the assembled value in the register picked by that write's address. If a write has data bit 7 set, the block drops any partly built value. It also forces the PRG mode field of the control register to the setting that keeps the upper bank fixed.

The CPU bus-cycle phase (M2) feeds a write filter. If a write arrives exactly one M2 rising edge after an accepted write, the block discards it. So when a read-modify-write instruction writes on two consecutive bus cycles, only the first write counts. When M2 is held still, the filter never engages and every write is accepted. The four register values go out directly to the bank address logic, which is not part of this block.

Top module: `serial_bank_loader`

## Requirements
- R1: After reset the control register reads 0x0C (bits 3:2 = 11) and CHR bank 0, CHR bank 1 and PRG bank read 0. No bits are pending.
- R2: Each accepted write with data bit 7 clear contributes its data bit 0. The first such bit becomes bit 0 of the stored value and the fifth becomes bit 4.
- R3: A value is stored only on the fifth accepted data write of a sequence. After four data writes, all registers still hold their old values.
- R4: Address bits 14:13 of the fifth write select the destination: 00 control, 01 CHR bank 0, 10 CHR bank 1, 11 PRG bank.
- R5: An accepted write with data bit 7 set clears the pending bits and the count at any address from 0x8000 to 0xFFFF. It adds no data bit, and it stores nothing in CHR bank 0, CHR bank 1 or PRG bank.
- R6: An accepted write with data bit 7 set sets control bits 3:2 to 11 and leaves control bits 4, 1 and 0 unchanged.
- R7: After a value is stored, the next data write starts a new five-write sequence.
- R8: A write is discarded when exactly one M2 rising edge has occurred since the last accepted write. This is the second write of a back-to-back pair. A discarded write changes no register and adds no bit.
- R9: A write that follows an accepted write with no M2 rising edge in between is accepted. Writes are also accepted when two or more rising edges have occurred.
- R10: Writes with address bit 15 clear change no register and add no bit. They do not disturb a sequence in progress.
- R11: At most one of the four registers changes on any clock edge. The change appears on the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one write is sampled per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m2 | input | 1 | CPU bus-cycle phase, sampled each clock |
| cpu_we | input | 1 | Write strobe, one write per clock it is high |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_data | input | 8 | CPU write data; bits 7 and 0 are used |
| ctrl_o | output | 5 | Control register (bits 3:2 PRG mode) |
| chr0_o | output | 5 | CHR bank 0 register |
| chr1_o | output | 5 | CHR bank 1 register |
| prg_o | output | 5 | PRG bank register |

## Verification
Every result appears on the same clock edge that samples the write. That covers a commit on the fifth write, the control mode change on a bit-7 write, and the absence of any change for dropped or low-address writes. The bench therefore drives stimulus on the falling edge and reads the outputs on the next falling edge. The filter depends on how many M2 rising edges the block has seen. So each bus cycle is driven as one clock with M2 low, then one clock with M2 high, with the write placed in the high clock. Back-to-back and held-M2 cases are built by leaving out the low clock or the idle cycle. A behavioural model updated on each rising edge is compared with all four outputs on every falling edge.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    typedef enum logic [1:0] {
        DST_CTRL = 2'd0,
        DST_CHR0 = 2'd1,
        DST_CHR1 = 2'd2,
        DST_PRG  = 2'd3
    } dest_e;

    localparam int NUM_REGS   = 4;
    localparam int MODE_LSB   = 2;
    localparam int GUARD_OPEN = 2;
endpackage

// File: rtl/sbl_guard.sv
module sbl_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic m2,
    input  logic wr_hit,
    output logic accept
);
    typedef struct packed {
        logic       m2;
        logic [1:0] edges;
    } guard_t;

    guard_t st_d, st_q;
    logic       rise;
    logic [1:0] eff;

    always_comb begin
        rise   = m2 & ~st_q.m2;
        eff    = (st_q.edges == 2'(sbl_pkg::GUARD_OPEN)) ? 2'(sbl_pkg::GUARD_OPEN)
                                                         : st_q.edges + {1'b0, rise};
        accept = wr_hit && (eff != 2'd1);
        st_d.m2    = m2;
        st_d.edges = accept ? 2'd0 : eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.m2    <= 1'b0;
            st_q.edges <= 2'(sbl_pkg::GUARD_OPEN);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter #(
    parameter int VAL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             bit_in,
    input  logic             abort,
    output logic             commit,
    output logic [VAL_W-1:0] value
);
    localparam int CNT_W = (VAL_W > 1) ? $clog2(VAL_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(VAL_W - 1);

    typedef struct packed {
        logic [VAL_W-1:0] sr;
        logic [CNT_W-1:0] n;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        value  = {bit_in, st_q.sr[VAL_W-1:1]};
        if (wr_en) begin
            if (abort) begin
                st_d = '0;
            end else if (st_q.n == LAST) begin
                commit = 1'b1;
                st_d   = '0;
            end else begin
                st_d.sr = value;
                st_d.n  = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sbl_regs.sv
module sbl_regs #(
    parameter int VAL_W = 5
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      commit,
    input  sbl_pkg::dest_e                            dest,
    input  logic [VAL_W-1:0]                          value,
    input  logic                                      force_mode,
    output logic [sbl_pkg::NUM_REGS-1:0][VAL_W-1:0]   bank_o
);
    localparam int ML = sbl_pkg::MODE_LSB;
    localparam logic [VAL_W-1:0] CTRL_INIT = VAL_W'(3) << ML;

    for (genvar g = 0; g < sbl_pkg::NUM_REGS; g++) begin : g_reg
        localparam logic [VAL_W-1:0] INIT = (g == 0) ? CTRL_INIT : '0;
        logic [VAL_W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (commit && (dest == sbl_pkg::dest_e'(g))) r_d = value;
            if ((g == 0) && force_mode) r_d[ML+1:ML] = 2'b11;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) r_q <= INIT;
            else        r_q <= r_d;
        end

        assign bank_o[g] = r_q;
    end
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int VAL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [VAL_W-1:0]  ctrl_o,
    output logic [VAL_W-1:0]  chr0_o,
    output logic [VAL_W-1:0]  chr1_o,
    output logic [VAL_W-1:0]  prg_o
);
    logic wr_hit, wr_ok, commit, abort;
    logic [VAL_W-1:0] value;
    sbl_pkg::dest_e dest;
    logic [sbl_pkg::NUM_REGS-1:0][VAL_W-1:0] bank;

    assign wr_hit = cpu_we & cpu_addr[ADDR_W-1];
    assign abort  = cpu_data[DATA_W-1];
    assign dest   = sbl_pkg::dest_e'(cpu_addr[ADDR_W-2 -: 2]);

    sbl_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .m2     (m2),
        .wr_hit (wr_hit),
        .accept (wr_ok)
    );

    sbl_shifter #(.VAL_W(VAL_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .bit_in (cpu_data[0]),
        .abort  (abort),
        .commit (commit),
        .value  (value)
    );

    sbl_regs #(.VAL_W(VAL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .dest       (dest),
        .value      (value),
        .force_mode (wr_ok & abort),
        .bank_o     (bank)
    );

    assign ctrl_o = bank[0];
    assign chr0_o = bank[1];
    assign chr1_o = bank[2];
    assign prg_o  = bank[3];
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int VAL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              accept,
    input logic [VAL_W-1:0]  ctrl,
    input logic [VAL_W-1:0]  chr0,
    input logic [VAL_W-1:0]  chr1,
    input logic [VAL_W-1:0]  prg
);
    a_r6_mode_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_data[DATA_W-1]) |=> (ctrl[3:2] == 2'b11 && ctrl[1:0] == $past(ctrl[1:0])
                                            && ctrl[VAL_W-1:4] == $past(ctrl[VAL_W-1:4])));

    a_r5_reset_stores_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_data[DATA_W-1]) |=> ($stable(chr0) && $stable(chr1) && $stable(prg)));

    a_r8_dropped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[ADDR_W-1] && !accept) |=>
        ($stable(ctrl) && $stable(chr0) && $stable(chr1) && $stable(prg)));

    a_r10_low_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cpu_addr[ADDR_W-1]) |=>
        ($stable(ctrl) && $stable(chr0) && $stable(chr1) && $stable(prg)));

    a_r10_accept_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cpu_we && cpu_addr[ADDR_W-1]));

    a_r11_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl != $past(ctrl), chr0 != $past(chr0), chr1 != $past(chr1), prg != $past(prg)}));
endmodule

bind serial_bank_loader sbl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .accept   (wr_ok),
    .ctrl     (ctrl_o),
    .chr0     (chr0_o),
    .chr1     (chr1_o),
    .prg      (prg_o)
);

// File: tb/test_serial_bank_loader.sv
module test_serial_bank_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m2 = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [4:0]  ctrl_o, chr0_o, chr1_o, prg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_bank_loader i_serial_bank_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .m2       (m2),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .ctrl_o   (ctrl_o),
        .chr0_o   (chr0_o),
        .chr1_o   (chr1_o),
        .prg_o    (prg_o)
    );

    // Behavioural reference model
    int mdl_reg [4];
    int mdl_sh, mdl_n, mdl_edges;
    bit mdl_m2;

    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_reg[0] = 12; mdl_reg[1] = 0; mdl_reg[2] = 0; mdl_reg[3] = 0;
            mdl_sh = 0; mdl_n = 0; mdl_edges = 2; mdl_m2 = 1'b0;
        end else begin
            int eff;
            eff = mdl_edges + ((m2 && !mdl_m2) ? 1 : 0);
            if (eff > 2) eff = 2;
            if (cpu_we && cpu_addr[15] && eff != 1) begin
                mdl_edges = 0;
                if (cpu_data[7]) begin
                    mdl_sh = 0; mdl_n = 0; mdl_reg[0] = mdl_reg[0] | 12;
                end else begin
                    mdl_sh = mdl_sh + (int'(cpu_data[0]) << mdl_n);
                    mdl_n++;
                    if (mdl_n == 5) begin
                        mdl_reg[int'(cpu_addr[14:13])] = mdl_sh;
                        mdl_sh = 0; mdl_n = 0;
                    end
                end
            end else begin
                mdl_edges = eff;
            end
            mdl_m2 = m2;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(ctrl_o) != mdl_reg[0] || int'(chr0_o) != mdl_reg[1] ||
                int'(chr1_o) != mdl_reg[2] || int'(prg_o) != mdl_reg[3]) begin
                errors++;
                $display("FAIL R11 model compare: got %h %h %h %h expected %h %h %h %h",
                         ctrl_o, chr0_o, chr1_o, prg_o,
                         mdl_reg[0], mdl_reg[1], mdl_reg[2], mdl_reg[3]);
            end
        end
    end

    task automatic expect_val(string tag, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle: M2 low clock, then M2 high clock carrying the write
    task automatic cyc(bit w, logic [15:0] a, logic [7:0] d);
        @(negedge clk); m2 = 1'b0; cpu_we = 1'b0;
        @(negedge clk); m2 = 1'b1; cpu_we = w; cpu_addr = a; cpu_data = d;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        cyc(1'b0, a, d);
        cyc(1'b1, a, d);
    endtask

    task automatic hold_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
    endtask

    task automatic settle();
        @(negedge clk); cpu_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(logic [15:0] a, logic [4:0] v);
        for (int i = 0; i < 5; i++) wr(a, {7'b0, v[i]});
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R1 ctrl reset", ctrl_o, 5'h0C);
        expect_val("R1 chr0 reset", chr0_o, 5'h00);
        expect_val("R1 chr1 reset", chr1_o, 5'h00);
        expect_val("R1 prg reset",  prg_o,  5'h00);

        load(16'h9FFF, 5'h10);
        expect_val("R2 ctrl lsb-first", ctrl_o, 5'h10);
        load(16'hBFFF, 5'h02);
        expect_val("R4 chr0 dest", chr0_o, 5'h02);
        load(16'hDFFF, 5'h13);
        expect_val("R4 chr1 dest", chr1_o, 5'h13);
        load(16'hE000, 5'h0A);
        expect_val("R4 prg dest", prg_o, 5'h0A);

        for (int i = 0; i < 4; i++) wr(16'h8000, 8'h01);
        settle();
        expect_val("R3 four writes no store", ctrl_o, 5'h10);
        wr(16'hC000, 8'h81);
        settle();
        expect_val("R6 mode forced", ctrl_o, 5'h1C);
        expect_val("R5 reset no store", chr1_o, 5'h13);
        load(16'hFFFF, 5'h05);
        expect_val("R5 abort restarts", prg_o, 5'h05);
        expect_val("R5 ctrl untouched", ctrl_o, 5'h1C);
        load(16'hA000, 5'h11);
        expect_val("R7 next sequence", chr0_o, 5'h11);

        // back-to-back pair: second write dropped
        wr(16'hB000, 8'h01);
        cyc(1'b1, 16'hB000, 8'h00);
        wr(16'hB000, 8'h01);
        wr(16'hB000, 8'h01);
        wr(16'hB000, 8'h00);
        settle();
        expect_val("R8 partial unchanged", chr0_o, 5'h11);
        wr(16'hB000, 8'h00);
        settle();
        expect_val("R8 rmw second dropped", chr0_o, 5'h07);

        // M2 held high: consecutive writes all accepted
        cyc(1'b0, 16'h0, 8'h0);
        cyc(1'b0, 16'h0, 8'h0);
        hold_wr(16'hD000, 8'h00);
        hold_wr(16'hD000, 8'h01);
        hold_wr(16'hD000, 8'h00);
        hold_wr(16'hD000, 8'h01);
        hold_wr(16'hD000, 8'h01);
        settle();
        expect_val("R9 held m2 accepted", chr1_o, 5'h1A);

        // low half writes ignored mid-sequence
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h00);
        wr(16'h7FFF, 8'h80);
        wr(16'h7000, 8'h01);
        settle();
        expect_val("R10 low write no effect", prg_o, 5'h05);
        expect_val("R10 ctrl unchanged", ctrl_o, 5'h1C);
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h00);
        settle();
        expect_val("R10 sequence intact", prg_o, 5'h0D);

        load(16'h8000, 5'h00);
        expect_val("R2 ctrl cleared", ctrl_o, 5'h00);
        wr(16'hFFFF, 8'hFF);
        settle();
        expect_val("R6 reset at top address", ctrl_o, 5'h0C);
        load(16'h9000, 5'h13);
        expect_val("R2 ctrl value", ctrl_o, 5'h13);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule